// File: doc/BRIEF.md
# Wide-to-Narrow APB Requester with Byte-Strobe Steering

This block sits between a 64-bit memory-mapped command source and a 32-bit APB bus. Each command carries a byte address and a direction. A write command also carries a full 64-bit data word and eight byte-enable bits. The requester turns each command into a single APB transfer. Address bit 2 selects which 32-bit half of the wide word, and which four of the eight enables, travel on the narrow bus. The transfer runs through a setup cycle and an access cycle, and it waits in the access cycle for as long as the completer holds PREADY low.

On a read, the completer's 32-bit data comes back inside the 64-bit response word, in the half that address bit 2 points to. The other half of the response is zero. The completer's error flag is returned with the response.

A strobe-compatibility mode lets the block drive completers that have no byte-enable input. The mode is sampled when a command is accepted. While it is in effect, the strobe pins copy the transfer direction onto every bit, so a write updates every byte lane.

Top module: `apb_narrow_requester`

## Requirements
- R1: `cmd_ready` is high only while no transfer is in progress. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- R2: In the cycle after a command is taken, `psel` is high and `penable` is low (setup). In the cycle after setup, `psel` and `penable` are both high (access).
- R3: The access phase lasts while `pready` is low. From setup until the completing access cycle, `paddr`, `pwrite`, `pwdata` and `pstrb` do not change.
- R4: For a write, `paddr` is the command address and `pwrite` is 1. When address bit 2 is 0, `pwdata` carries data bits 31:0 and `pstrb` carries enable bits 3:0. When address bit 2 is 1, they carry data bits 63:32 and enable bits 7:4. `pstrb` bit n qualifies `pwdata` bits 8n+7 down to 8n. All four data lanes carry the selected data even where the enable bit is 0.
- R5: For a read, `pwrite` is 0, every `pstrb` bit is 0, and `pwdata` is all zeros.
- R6: When `legacy_strb` is 1 at acceptance, `pstrb` is all ones for a write and all zeros for a read, whatever `cmd_wstrb` holds.
- R7: Each command produces exactly one response. `rsp_valid` is high for one cycle, namely the cycle after the completing access cycle, and `psel` is low in that cycle.
- R8: For a read response, `prdata` sampled in the completing cycle appears in `rsp_rdata` bits 31:0 when address bit 2 was 0, or in bits 63:32 when it was 1. The other half is zero. A write response has `rsp_rdata` equal to zero.
- R9: `rsp_err` equals `pslverr` as sampled in the completing access cycle.
- R10: After reset, `psel`, `penable` and `rsp_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Requester can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | WIDE_W | Wide write data |
| cmd_wstrb | input | WIDE_W/8 | Wide byte enables |
| legacy_strb | input | 1 | Strobe-compatibility mode, sampled at acceptance |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | WIDE_W | Read data placed in the addressed half |
| rsp_err | output | 1 | Completer error for this command |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | APB_W | APB write data |
| pstrb | output | APB_W/8 | APB byte strobes |
| prdata | input | APB_W | APB read data |
| pready | input | 1 | APB completer ready |
| pslverr | input | 1 | APB completer error |

## Verification
The assertions check the protocol on every cycle. They cover the setup-to-access sequence, the holding of the access phase while wait states last, the stability of address, direction, data and strobe across the transfer, the zero strobe on reads, and the timing of the response pulse together with the error flag it carries. The lane choice cannot be seen from the protocol alone: which half of the wide data and enables goes out, the exact strobe value, the substitution in compatibility mode, and the placement of read data in the response. Only the bench can show these, because it computes the expected values for every enable pattern, both halves, both modes and a range of wait-state counts.

// File: rtl/apb_narrow_requester.sv
module apb_narrow_requester #(
  parameter int ADDR_W = 32,
  parameter int WIDE_W = 64,
  parameter int APB_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [WIDE_W-1:0]   cmd_wdata,
  input  logic [WIDE_W/8-1:0] cmd_wstrb,
  input  logic                legacy_strb,
  output logic                rsp_valid,
  output logic [WIDE_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                psel,
  output logic                penable,
  output logic                pwrite,
  output logic [ADDR_W-1:0]   paddr,
  output logic [APB_W-1:0]    pwdata,
  output logic [APB_W/8-1:0]  pstrb,
  input  logic [APB_W-1:0]    prdata,
  input  logic                pready,
  input  logic                pslverr
);
  localparam int NB    = APB_W / 8;
  localparam int RATIO = WIDE_W / APB_W;
  localparam int LO    = $clog2(NB);
  localparam int SELW  = (RATIO > 1) ? $clog2(RATIO) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS} st_t;

  st_t              st;
  logic [SELW-1:0]  sel_q;
  logic [SELW-1:0]  cmd_sel;
  logic [WIDE_W-1:0] rd_place;
  logic             accept;
  logic             done;

  assign cmd_sel   = cmd_addr[LO +: SELW];
  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign psel      = (st != S_IDLE);
  assign penable   = (st == S_ACCESS);
  assign done      = (st == S_ACCESS) && pready;

  always_comb begin
    rd_place = '0;
    rd_place[int'(sel_q)*APB_W +: APB_W] = prdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel_q     <= '0;
      pwrite    <= 1'b0;
      paddr     <= '0;
      pwdata    <= '0;
      pstrb     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_SETUP;
          sel_q  <= cmd_sel;
          pwrite <= cmd_write;
          paddr  <= cmd_addr;
          pwdata <= cmd_write ? cmd_wdata[int'(cmd_sel)*APB_W +: APB_W] : '0;
          if (legacy_strb) pstrb <= {NB{cmd_write}};
          else             pstrb <= cmd_write ? cmd_wstrb[int'(cmd_sel)*NB +: NB] : '0;
        end
        S_SETUP: st <= S_ACCESS;
        S_ACCESS: if (done) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= pslverr;
          rsp_rdata <= pwrite ? '0 : rd_place;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apb_narrow_requester_chk.sv
module apb_narrow_requester_chk #(
  parameter int ADDR_W = 32,
  parameter int APB_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [APB_W-1:0]  pwdata,
  input logic [APB_W/8-1:0] pstrb,
  input logic              pready,
  input logic              pslverr,
  input logic              rsp_valid,
  input logic              rsp_err
);
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !psel) else $error("AST_IDLE_READY"); // R1
  AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> psel && !penable) else $error("AST_ACCEPT_SETUP"); // R2
  AST_SETUP_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !penable |=> psel && penable) else $error("AST_SETUP_ACCESS"); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && !pready |=> psel && penable) else $error("AST_WAIT_HOLD"); // R3
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !(penable && pready) |=> $stable({pwrite, paddr, pwdata, pstrb})) else $error("AST_FIELDS_STABLE"); // R3
  AST_READ_STRB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !pwrite |-> pstrb == '0) else $error("AST_READ_STRB_ZERO"); // R5
  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && pready |=> rsp_valid && !psel) else $error("AST_RSP_AFTER_DONE"); // R7
  AST_RSP_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pready) |=> !rsp_valid) else $error("AST_RSP_ONLY_DONE"); // R7
  AST_RSP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && pready |=> rsp_err == $past(pslverr)) else $error("AST_RSP_ERR"); // R9
endmodule

bind apb_narrow_requester apb_narrow_requester_chk #(.ADDR_W(ADDR_W), .APB_W(APB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .pwdata(pwdata), .pstrb(pstrb), .pready(pready), .pslverr(pslverr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/apb_narrow_requester_test.sv
module apb_narrow_requester_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_ready, cmd_write = 0, legacy_strb = 0;
  logic [31:0] cmd_addr = 0;
  logic [63:0] cmd_wdata = 0;
  logic [7:0]  cmd_wstrb = 0;
  logic        rsp_valid, rsp_err, psel, penable, pwrite;
  logic [63:0] rsp_rdata;
  logic [31:0] paddr, pwdata, prdata = 0;
  logic [3:0]  pstrb;
  logic        pready = 0, pslverr = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  apb_narrow_requester uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_wstrb(cmd_wstrb), .legacy_strb(legacy_strb), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [31:0] addr, input logic [63:0] wd,
                     input logic [7:0] ws, input bit leg, input int waits,
                     input bit err, input logic [31:0] rd);
    bit sel = addr[2];
    logic [31:0] e_wd  = wr ? (sel ? wd[63:32] : wd[31:0]) : 32'h0;
    logic [3:0]  e_st  = !wr ? 4'h0 : (leg ? 4'hF : (sel ? ws[7:4] : ws[3:0]));
    logic [63:0] e_rsp = wr ? 64'h0 : (sel ? {rd, 32'h0} : {32'h0, rd});
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", 64'(cmd_ready), 64'h1);
    cmd_valid = 1; cmd_write = wr; cmd_addr = addr; cmd_wdata = wd;
    cmd_wstrb = ws; legacy_strb = leg;
    @(negedge clk);
    cmd_valid = 0; cmd_wstrb = ~ws; cmd_wdata = ~wd; legacy_strb = ~leg;
    chk(psel && !penable, "R2 setup phase", 64'({psel, penable}), 64'h2);
    chk(cmd_ready == 1'b0, "R1 busy not ready", 64'(cmd_ready), 64'h0);
    chk(paddr == addr && pwrite == wr, "R4 address and direction", 64'({pwrite, paddr}), 64'({wr, addr}));
    chk(pwdata == e_wd, wr ? "R4 write data half" : "R5 read data zero", 64'(pwdata), 64'(e_wd));
    chk(pstrb == e_st, leg ? "R6 legacy strobe" : (wr ? "R4 strobe half" : "R5 read strobe zero"),
        64'(pstrb), 64'(e_st));
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      chk(psel && penable, "R3 access held", 64'({psel, penable}), 64'h3);
      chk(paddr == addr && pwdata == e_wd && pstrb == e_st && pwrite == wr, "R3 fields stable",
          64'({pstrb, pwdata}), 64'({e_st, e_wd}));
      chk(rsp_valid == 1'b0, "R7 no early response", 64'(rsp_valid), 64'h0);
      pready = (i == waits); pslverr = err; prdata = rd;
    end
    @(negedge clk);
    pready = 0; pslverr = ~err; prdata = ~rd;
    chk(rsp_valid && !psel, "R7 response pulse", 64'({rsp_valid, psel}), 64'h2);
    chk(rsp_rdata == e_rsp, "R8 response data placement", rsp_rdata, e_rsp);
    chk(rsp_err == err, "R9 error returned", 64'(rsp_err), 64'(err));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 single response", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!psel && !penable && !rsp_valid && cmd_ready, "R10 reset state",
        64'({psel, penable, rsp_valid, cmd_ready}), 64'h1);
    rst_n = 1;
    for (int leg = 0; leg < 2; leg++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 256; w++)
          run(1'b1, 32'h4000_0000 | (w << 3) | (s << 2), {8{w[7:0] ^ 8'h5A}} ^ 64'h0123_4567_89AB_CDEF * (w + 1),
              w[7:0], leg[0], w % 3, w[0] ^ s[0], 32'h0);
    for (int leg = 0; leg < 2; leg++)
      for (int s = 0; s < 2; s++)
        for (int wt = 0; wt < 5; wt++)
          for (int e = 0; e < 2; e++)
            run(1'b0, 32'h1000_0010 | (wt << 4) | (s << 2), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, leg[0], wt,
                e[0], 32'hC0DE_0000 | (wt << 8) | (s << 4) | e);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule